// File: doc/BRIEF.md
# Two-Compare Pulse Generator Timer

This block produces a square wave of programmable period and duty on one output pin. A 16-bit up counter advances on cycles where a prescaled count-enable input is high. Two compare values are held: a duty compare and a period compare. When the counter equals the duty compare on a counted cycle, the output flip-flop inverts and a one-cycle duty interrupt fires. When the counter equals the period compare on a counted cycle, the flip-flop inverts again and a one-cycle period interrupt fires. The counter then returns to zero instead of advancing. A period therefore spans the period compare plus one counted cycles. The duty compare must stay below the period compare.

The duty compare can be written directly, or through a staging buffer when double buffering is on. With buffering on, the staged value is copied into the duty compare only at the period match, so a duty change never tears a period. While the timer is stopped, software can force the flip-flop to either level. This choice of starting level makes the pulse active high or active low. Raising the run input clears the counter to zero.

Top module: `ppg_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pulse_out`, `irq_duty` and `irq_period` are 0 after that edge, and both compare values and the staging buffer are cleared to 0.
- R2: A cycle is counted when `run` and `cnt_en` are high and `run` was also high on the previous cycle. On a counted cycle the counter goes to counter+1, or to 0 if it equals the period compare. With constant enable, `irq_period` pulses once every (period compare + 1) counted cycles.
- R3: On a counted cycle where the counter equals the duty compare, `irq_duty` is high for exactly the following cycle and `pulse_out` inverts at the same edge.
- R4: On a counted cycle where the counter equals the period compare, `irq_period` is high for exactly the following cycle and `pulse_out` inverts at the same edge. If both matches occur together, the output does not change.
- R5: On a cycle that is not counted, the counter holds, no interrupt is raised, and `pulse_out` does not change unless it is forced (R9).
- R6: With `dbuf_en`=1, a write with `wr_sel`=0 (duty) stores `wr_data` in the staging buffer only. The buffer is copied into the duty compare on a period match.
- R7: With `dbuf_en`=0, a write with `wr_sel`=0 replaces the duty compare at that edge.
- R8: With `dbuf_en`=1, if a duty write and a period match fall on the same edge, the written value goes into the buffer and the previous buffer value goes into the duty compare.
- R9: While `run` is low, `ff_set`=1 loads `ff_level` into `pulse_out` at the next edge. `ff_set` is ignored while `run` is high.
- R10: On the first cycle with `run` high after a cycle with it low, the counter clears to 0, and no match is checked on that cycle.
- R11: A write with `wr_sel`=1 (period) replaces the period compare at that edge, whatever `dbuf_en` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Timer runs while high; a rising level restarts the count at 0 |
| cnt_en | input | 1 | Prescaled count enable |
| dbuf_en | input | 1 | Routes duty writes through the staging buffer |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 duty compare, 1 period compare |
| wr_data | input | 16 | Write value |
| ff_set | input | 1 | Force the output flip-flop while stopped |
| ff_level | input | 1 | Level loaded by `ff_set` |
| pulse_out | output | 1 | Pulse output flip-flop |
| irq_duty | output | 1 | One-cycle duty-match interrupt |
| irq_period | output | 1 | One-cycle period-match interrupt |

## Verification
The bench drives the buffered transfer hardest, including duty writes that land on the exact edge of a period match. If the buffer and compare updates were ordered the other way, the new value would take effect a period early, or the old value would be lost. Stalls in `cnt_en` while the counter sits on a match value are checked. A design that compares on every cycle instead of on counted cycles would repeat interrupts and toggle the output more than once. Restarts and equal compare values are also exercised. A counter that skips the clear on restart would shift every edge. A design that lets simultaneous matches both toggle would report the wrong output level.

// File: rtl/ppg_pkg.sv
// Shared types for the pulse generator timer.
package ppg_pkg;
    // Selects the compare register a bus write targets.
    typedef enum logic {
        SEL_DUTY   = 1'b0,
        SEL_PERIOD = 1'b1
    } ppg_sel_e;

    // Match events produced by the counter on a counted cycle.
    typedef struct packed {
        logic duty;
        logic period;
    } ppg_hit_t;
endpackage

// File: rtl/ppg_regs.sv
// Compare register bank: the duty compare (optionally staged through a buffer)
// and the period compare. Assumes xfer is a period match on a counted cycle.
module ppg_regs #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         dbuf_en,
    input  logic         xfer,
    output logic [W-1:0] cmp_duty,
    output logic [W-1:0] cmp_period
);
    import ppg_pkg::*;

    logic [W-1:0] stage_q;
    logic         wr_duty;
    logic         wr_period;

    // Decode the write target.
    always_comb begin
        wr_duty   = wr_en && (ppg_sel_e'(wr_sel) == SEL_DUTY);
        wr_period = wr_en && (ppg_sel_e'(wr_sel) == SEL_PERIOD);
    end

    // Staging buffer captures duty writes when buffering is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= '0;
        else if (wr_duty && dbuf_en)
            stage_q <= wr_data;
    end

    // Duty compare: direct write, or buffer transfer at period end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_duty <= '0;
        else if (dbuf_en) begin
            if (xfer)
                cmp_duty <= stage_q;
        end else if (wr_duty)
            cmp_duty <= wr_data;
    end

    // Period compare is always written directly.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_period <= '0;
        else if (wr_period)
            cmp_period <= wr_data;
    end

    // R6: a buffered duty write without a transfer leaves the duty compare alone.
    a_r6_buffer_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_duty && dbuf_en && !xfer) |=> (cmp_duty == $past(cmp_duty)));

    // R8: on a transfer the duty compare takes the buffer's old content.
    a_r8_xfer_old: assert property (@(posedge clk) disable iff (!rst_n)
        (dbuf_en && xfer) |=> (cmp_duty == $past(stage_q)));

    // R11: a period write lands at once.
    a_r11_period_wr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_period |=> (cmp_period == $past(wr_data)));
endmodule

// File: rtl/ppg_counter.sv
// Up counter with restart and period wrap. Flags duty and period matches on
// counted cycles only. Assumes cnt_en is a one-cycle prescaler strobe.
module ppg_counter #(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cnt_en,
    input  logic [W-1:0]      cmp_duty,
    input  logic [W-1:0]      cmp_period,
    output ppg_pkg::ppg_hit_t hit
);
    logic [W-1:0] cnt_q;
    logic         run_q;
    logic         start;
    logic         counted;

    // Qualify the cycle: restart edge or counted step.
    always_comb begin
        start      = run && !run_q;
        counted    = run && cnt_en && !start;
        hit.duty   = counted && (cnt_q == cmp_duty);
        hit.period = counted && (cnt_q == cmp_period);
    end

    // Remember the previous run level to find the restart edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else
            run_q <= run;
    end

    // Count, wrap at the period match, clear on restart.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= '0;
        else if (counted)
            cnt_q <= hit.period ? '0 : cnt_q + 1'b1;
    end

    // R5: the counter holds on cycles that neither count nor restart.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && (cnt_en || !run_q)) |=> $stable(cnt_q));

    // R2: a period match returns the counter to zero.
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        hit.period |=> (cnt_q == '0));

    // R10: a restart edge clears the counter.
    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !run_q) |=> (cnt_q == '0));
endmodule

// File: rtl/ppg_outff.sv
// Output flip-flop and interrupt pulses. Toggles on each match, forced while
// stopped. Assumes hits are already qualified by counted cycles.
module ppg_outff (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              ff_set,
    input  logic              ff_level,
    input  ppg_pkg::ppg_hit_t hit,
    output logic              pulse_q,
    output logic              irq_duty_q,
    output logic              irq_period_q
);
    // Flip-flop: forced while stopped, toggled once per match while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_q <= 1'b0;
        else if (!run && ff_set)
            pulse_q <= ff_level;
        else if (run && (hit.duty ^ hit.period))
            pulse_q <= !pulse_q;
    end

    // Register the one-cycle interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_duty_q   <= 1'b0;
            irq_period_q <= 1'b0;
        end else begin
            irq_duty_q   <= hit.duty;
            irq_period_q <= hit.period;
        end
    end

    // R3/R4: a lone interrupt comes with an inverted output.
    a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_duty_q ^ irq_period_q) |-> (pulse_q != $past(pulse_q)));

    // R9: forcing while stopped loads the programmed level.
    a_r9_force: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && ff_set) |=> (pulse_q == $past(ff_level)));
endmodule

// File: rtl/ppg_timer.sv
// Top of the two-compare pulse generator timer. Connects the compare bank,
// the counter and the output stage. Assumes duty compare < period compare
// for a well-formed pulse.
module ppg_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cnt_en,
    input  logic             dbuf_en,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ff_set,
    input  logic             ff_level,
    output logic             pulse_out,
    output logic             irq_duty,
    output logic             irq_period
);
    import ppg_pkg::*;

    logic [CNT_W-1:0] cmp_duty;
    logic [CNT_W-1:0] cmp_period;
    ppg_hit_t         hit;

    ppg_regs #(.W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .dbuf_en    (dbuf_en),
        .xfer       (hit.period),
        .cmp_duty   (cmp_duty),
        .cmp_period (cmp_period)
    );

    ppg_counter #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .cnt_en     (cnt_en),
        .cmp_duty   (cmp_duty),
        .cmp_period (cmp_period),
        .hit        (hit)
    );

    ppg_outff u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .ff_set       (ff_set),
        .ff_level     (ff_level),
        .hit          (hit),
        .pulse_q      (pulse_out),
        .irq_duty_q   (irq_duty),
        .irq_period_q (irq_period)
    );

    // R3/R4: interrupts are single-cycle pulses while the count stalls.
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_period && !cnt_en) |=> !irq_period);
endmodule

// File: tb/tb_ppg_timer.sv
module tb_ppg_timer;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n, run, cnt_en, dbuf_en, wr_en, wr_sel, ff_set, ff_level;
    logic [W-1:0] wr_data;
    logic         pulse_out, irq_duty, irq_period;

    ppg_timer #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .run(run), .cnt_en(cnt_en), .dbuf_en(dbuf_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .ff_set(ff_set),
        .ff_level(ff_level), .pulse_out(pulse_out), .irq_duty(irq_duty),
        .irq_period(irq_period)
    );

    always #4 clk = !clk;   // 125 MHz

    int n_tests = 0;
    int n_fail  = 0;
    int seen_duty = 0;
    int seen_period = 0;
    bit checking = 1'b0;
    string lbl = "R1";

    // Reference state predicted from the requirements.
    logic [W-1:0] m_cnt, m_duty, m_per, m_buf;
    logic         m_ff, m_i0, m_i1, m_runq;

    task automatic chk(input string req, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare outputs with the prediction made at the previous negedge.
    task automatic compare_outputs();
        chk(lbl, "pulse_out",  W'(pulse_out),  W'(m_ff));
        chk(lbl, "irq_duty",   W'(irq_duty),   W'(m_i0));
        chk(lbl, "irq_period", W'(irq_period), W'(m_i1));
        if (irq_duty)   seen_duty++;
        if (irq_period) seen_period++;
    endtask

    // Predict the state after the coming edge from the requirements.
    function automatic void predict();
        logic start, counted, h0, h1, wd, wp;
        if (!rst_n) begin
            m_cnt = '0; m_duty = '0; m_per = '0; m_buf = '0;
            m_ff = 1'b0; m_i0 = 1'b0; m_i1 = 1'b0; m_runq = 1'b0;
            lbl = "R1";
            return;
        end
        start   = run && !m_runq;                           // R10
        counted = run && cnt_en && !start;                  // R2
        h0 = counted && (m_cnt == m_duty);                  // R3
        h1 = counted && (m_cnt == m_per);                   // R4
        wd = wr_en && !wr_sel;
        wp = wr_en && wr_sel;
        if (wd && dbuf_en && h1)      lbl = "R8";
        else if (h1 && dbuf_en)       lbl = "R6";
        else if (wd && !dbuf_en)      lbl = "R7";
        else if (wp)                  lbl = "R11";
        else if (!run && ff_set)      lbl = "R9";
        else if (start)               lbl = "R10";
        else if (run && !counted)     lbl = "R5";
        else if (h0)                  lbl = "R3";
        else if (h1)                  lbl = "R4";
        else                          lbl = "R2";
        if (dbuf_en) begin
            if (h1) m_duty = m_buf;                         // R6/R8
            if (wd) m_buf = wr_data;
        end else if (wd) m_duty = wr_data;                  // R7
        if (wp) m_per = wr_data;                            // R11
        if (!run && ff_set) m_ff = ff_level;                // R9
        else if (run && (h0 ^ h1)) m_ff = !m_ff;
        if (start) m_cnt = '0;
        else if (counted) m_cnt = h1 ? '0 : m_cnt + 1'b1;
        m_i0 = h0; m_i1 = h1; m_runq = run;
    endfunction

    task automatic step(input logic r, input logic ce, input logic db, input logic we,
                        input logic ws, input logic [W-1:0] wd, input logic fs,
                        input logic fl, input logic rn);
        @(negedge clk);
        if (checking) compare_outputs();
        run = r; cnt_en = ce; dbuf_en = db; wr_en = we; wr_sel = ws;
        wr_data = wd; ff_set = fs; ff_level = fl; rst_n = rn;
        predict();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unused;
        unused = $urandom(32'h5eed_1234);
        rst_n = 1'b0; run = 0; cnt_en = 0; dbuf_en = 0; wr_en = 0; wr_sel = 0;
        wr_data = '0; ff_set = 0; ff_level = 0;
        predict();
        repeat (4) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
        checking = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0, 0, 1);             // R1 reset values checked
        // Directed: duty 2, period 5, force low, run with constant enable.
        step(0, 0, 0, 1, 0, 16'd2, 0, 0, 1);
        step(0, 0, 0, 1, 1, 16'd5, 1, 0, 1);
        step(1, 1, 0, 0, 0, 0, 0, 0, 1);             // R10 restart
        seen_duty = 0; seen_period = 0;
        repeat (60) step(1, 1, 0, 0, 0, 0, 0, 0, 1);
        step(1, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R2", "period pulses in 60 counts", W'(seen_period), 16'd10);
        chk("R3", "duty pulses in 60 counts", W'(seen_duty), 16'd10);
        // R5: long stall raises nothing.
        seen_duty = 0; seen_period = 0;
        repeat (20) step(1, 0, 0, 0, 0, 0, 0, 0, 1);
        step(1, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R5", "pulses during stall", W'(seen_duty + seen_period), 16'd0);
        // R9: force high while stopped, ignored while running.
        step(0, 0, 0, 0, 0, 0, 1, 1, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R9", "forced level", W'(pulse_out), 16'd1);
        step(1, 0, 0, 0, 0, 0, 1, 0, 1);
        step(1, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R9", "force ignored while running", W'(pulse_out), 16'd1);
        // Equal compares: both match, output unchanged (R4).
        step(0, 0, 0, 1, 0, 16'd3, 0, 0, 1);
        step(0, 0, 0, 1, 1, 16'd3, 0, 0, 1);
        repeat (12) step(1, 1, 0, 0, 0, 0, 0, 0, 1);
        // Random phase with small compare values.
        for (int i = 0; i < 30000; i++) begin
            logic r, ce, db, we, ws, fs, fl;
            logic [W-1:0] wd;
            r  = ($urandom_range(0, 40) != 0);
            ce = ($urandom_range(0, 3) != 0);
            db = ($urandom_range(0, 3) != 0);
            we = ($urandom_range(0, 5) == 0);
            ws = ($urandom_range(0, 3) == 0);
            wd = ws ? W'($urandom_range(4, 12)) : W'($urandom_range(0, 6));
            if ($urandom_range(0, 300) == 0) wd = W'($urandom);
            fs = ($urandom_range(0, 2) == 0);
            fl = 1'($urandom);
            step(r, ce, db, we, ws, wd, fs, fl, 1);
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule